// File: doc/BRIEF.md
# Exhaustive Syndrome-Test Controller

This block runs a built-in syndrome test on a combinational function that has N inputs and one output. When it is started, it applies every one of the 2^N input vectors once, in ascending binary order, one vector per clock. It counts how many times the response bit is 1 over the whole sweep. That count K, divided by 2^N, is the syndrome of the function.

At the end of the sweep, K is compared with an expected count supplied from outside. The expected count is worked out offline for the fault-free circuit; for example, K = 1 for an N-input AND and K = 2^N - 1 for an N-input OR. The controller raises done, sets the result of the comparison on pass, and keeps both, together with the raw count, until the next start. The response is sampled one cycle after its vector is driven, so the circuit under test may place one register between the vector and the response.

Top module: `syndrome_bist`

## Requirements
- R1: While rst_n is low at a rising edge (synchronous, active low), the following outputs are 0 after that edge: busy, done, pass, k_count and vec.
- R2: A start that is high at an edge while busy is low begins a sweep. After that edge, busy is 1, done and pass are 0, and vec is 0.
- R3: During a sweep, vec takes the values 0, 1, ..., 2^N-1 in ascending order. It takes one value per cycle and each value exactly once.
- R4: The response bit present in the cycle after vector v is driven is the one counted for v, so a registered circuit under test is counted correctly.
- R5: k_count is N+1 bits wide and ends each sweep equal to the number of counted ones, including the full value 2^N.
- R6: done rises exactly 2^N + 1 edges after the start edge, and busy falls at that same edge. done and busy are never high together.
- R7: At completion, pass is 1 exactly when the final count equals expect_k, which is sampled in the last cycle that busy is high.
- R8: After completion, done, pass and k_count keep their values until a new sweep is started, whatever resp and expect_k do.
- R9: start is ignored while busy is high. The sweep in progress keeps its order, its count and its finishing cycle.
- R10: With a fault-free N-input AND the final count is 1, and with an N-input OR it is 2^N - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a sweep when busy is low |
| expect_k | input | N+1 | Expected count of ones for the fault-free circuit |
| resp | input | 1 | Response bit from the circuit under test |
| vec | output | N | Input vector driven to the circuit under test |
| busy | output | 1 | Sweep or final sample in progress |
| done | output | 1 | Sweep finished; held until the next start |
| pass | output | 1 | Final count matched expect_k; held until the next start |
| k_count | output | N+1 | Raw count of ones |

## Verification
The hardest case to reach is the sample of the last vector. That sample arrives only after vec has already wrapped to zero and the sweep state has been left, so an error in the one-cycle delay drops or double-counts it. The stimulus uses a registered model of the circuit under test. It sweeps functions whose only 1 sits at the first vector or at the last vector (AND), and a constant-1 function whose count needs the extra top bit. A start pulse placed in the middle of a sweep shows whether the sweep is disturbed or restarted.

// File: rtl/syndrome_bist.sv
module syndrome_bist #(
  parameter int N = 4,
  localparam int KW = N + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] expect_k,
  input  logic          resp,
  output logic [N-1:0]  vec,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic [KW-1:0] k_count
);

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;

  st_t           st_q;
  logic [N-1:0]  vec_q;
  logic [KW-1:0] cnt_q;
  logic          smp_q, done_q, pass_q;

  wire [KW-1:0] cnt_nxt = cnt_q + {{N{1'b0}}, resp};
  wire          go      = start && !busy;

  assign busy    = (st_q == RUN) || smp_q;
  assign vec     = vec_q;
  assign done    = done_q;
  assign pass    = pass_q;
  assign k_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= IDLE;
      vec_q  <= '0;
      cnt_q  <= '0;
      smp_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      smp_q <= (st_q == RUN);
      if (smp_q) cnt_q <= cnt_nxt;
      case (st_q)
        RUN: begin
          vec_q <= vec_q + 1'b1;
          if (&vec_q) st_q <= FIN;
        end
        default: begin
          if (smp_q) begin
            done_q <= 1'b1;
            pass_q <= (cnt_nxt == expect_k);
          end
          if (go) begin
            st_q   <= RUN;
            vec_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            pass_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !pass && vec == '0));

  assert_vec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RUN) |=> (vec == N'($past(vec) + 1'b1)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    k_count <= (KW'(1) << N));

  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass) && $stable(k_count)));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && smp_q && st_q == RUN) |=> busy);

endmodule

// File: tb/tb_syndrome_bist.sv
module tb_syndrome_bist;
  localparam int N  = 4;
  localparam int KW = N + 1;
  localparam int NV = 1 << N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, resp;
  logic [KW-1:0] expect_k = '0;
  logic [N-1:0] vec;
  logic busy, done, pass;
  logic [KW-1:0] k_count;
  int mode = 0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  syndrome_bist #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .expect_k(expect_k),
    .resp(resp), .vec(vec), .busy(busy), .done(done), .pass(pass),
    .k_count(k_count));

  // Registered model of the circuit under test
  function automatic logic cut_f(int m, logic [N-1:0] v);
    case (m)
      0: return &v;
      1: return |v;
      2: return ^v;
      3: return 1'b1;
      4: return 1'b0;
      default: return (v == '0);
    endcase
  endfunction

  always_ff @(posedge clk) resp <= cut_f(mode, vec);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full sweep; optional mid-run start pulse at vector index pulse_at
  task automatic sweep(int m, int exp_k, int pulse_at, string tag);
    int bad = 0;
    mode = m;
    expect_k = KW'(exp_k);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " R2 busy"}, busy, 1);
    chk({tag, " R2 done"}, done, 0);
    chk({tag, " R2 vec"}, vec, 0);
    for (int i = 0; i < NV; i++) begin
      if (vec != N'(i) || !busy || done) bad++;
      start = (i == pulse_at);
      @(negedge clk);
    end
    start = 1'b0;
    chk({tag, " R3 ascending sweep"}, bad, 0);
    chk({tag, " R6 not done early"}, done, 0);
    @(negedge clk);
    chk({tag, " R6 done timing"}, done, 1);
    chk({tag, " R6 busy fell"}, busy, 0);
    chk({tag, " R5 count"}, k_count, exp_k);
    chk({tag, " R7 pass"}, pass, 1);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 pass", pass, 0);
    chk("R1 count", k_count, 0);
    chk("R1 vec", vec, 0);
  endtask

  task automatic t_and_or();
    sweep(0, 1, -1, "R10 AND");
    sweep(1, NV - 1, -1, "R10 OR");
  endtask

  task automatic t_parity_full();
    sweep(2, NV / 2, -1, "parity");
    sweep(3, NV, -1, "R5 full count");
    sweep(4, 0, -1, "zero");
  endtask

  task automatic t_latency();
    sweep(5, 1, -1, "R4 first vector");
  endtask

  task automatic t_mismatch();
    mode = 0;
    expect_k = KW'(2);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (NV + 1) @(negedge clk);
    chk("R7 mismatch done", done, 1);
    chk("R7 mismatch pass", pass, 0);
    chk("R7 mismatch count", k_count, 1);
  endtask

  task automatic t_hold();
    mode = 3;
    expect_k = '0;
    repeat (6) @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 pass held", pass, 0);
    chk("R8 count held", k_count, 1);
    chk("R8 vec idle", vec, 0);
  endtask

  task automatic t_busy_start();
    sweep(1, NV - 1, 5, "R9 start while busy");
    @(negedge clk);
    chk("R9 no restart", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_and_or();
    t_parity_full();
    t_latency();
    t_mismatch();
    t_hold();
    t_busy_start();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule